// File: doc/BRIEF.md
# Network Controller Command Register

This block is the command register of a packet network controller. A host sets its command bits over a simple register bus. The block turns those bits into an enable level for the receive buffer engine and start and halt control for the transmit sequencer. A MAC-side status interface tells it when a packet is being received, when the wire is active, and when transmit events occur. The block uses these to delay receive changes to packet boundaries and to clear command bits when their commands finish.

The receive side is a four-state machine:
- `RX_OFF`: disable bit set, no buffering.
- `RX_ON`: enable bit set, buffering.
- `RX_EN_WAIT`: both bits set, buffering not yet started.
- `RX_DIS_WAIT`: both bits set, still buffering until the packet ends.

Its transitions are:
- Immediate enable: `RX_OFF` to `RX_ON`.
- Deferred enable: `RX_OFF` to `RX_EN_WAIT`.
- Enable taking effect: `RX_EN_WAIT` to `RX_ON`.
- Enable cancel: `RX_EN_WAIT` to `RX_OFF`.
- Immediate disable: `RX_ON` to `RX_OFF`.
- Deferred disable: `RX_ON` to `RX_DIS_WAIT`.
- Disable taking effect: `RX_DIS_WAIT` to `RX_OFF`.
- Disable cancel: `RX_DIS_WAIT` to `RX_ON`.
- Software reset: any state to `RX_OFF`.

The transmit side has two states, `TX_IDLE` and `TX_RUN`, with a halt bit alongside them. Its transitions are:
- Start: `TX_IDLE` to `TX_RUN`.
- Refused start, on a load conflict: stays in `TX_IDLE`.
- Completion, abort or halt: `TX_RUN` to `TX_IDLE`.
- Software reset: any state to `TX_IDLE`.

Command word bit positions:
- bit 0: receive enable
- bit 1: receive disable
- bit 2: transmit go
- bit 3: transmit halt

Writing 1 to a bit issues that command. Writing 0 has no effect, except for the cancel cases in R4. Bits above 3 are ignored on write and read as 0.

Top module: `netctl_cmd_reg`

## Requirements
- R1: Writing 1 to bit 0 while `rx_busy` is low moves the receiver straight to enabled. The register then reads 0x01 (disable bit cleared), and `rx_buf_en` rises one cycle after the write.
- R2: Writing 1 to bit 0 while `rx_busy` is high makes bits 0 and 1 both read 1 and keeps `rx_buf_en` low. The enable takes effect, and the register reads 0x01, in the cycle after the first edge at which `net_active` is low.
- R3: Writing 1 to bit 1 while enabled and `rx_busy` is high makes both receive bits read 1 and keeps `rx_buf_en` high while `rx_busy` stays high. After the first edge with `rx_busy` low, the register reads 0x02 and `rx_buf_en` is low.
- R4: While both receive bits are set, a write with bit 0 = 0 cancels a pending enable and returns to disabled (reads 0x02). A write with bit 1 = 0 cancels a pending disable and returns to enabled (reads 0x01).
- R5: Writing 1 to bit 2 while idle and `cam_busy` is low does three things one cycle later: it pulses `tx_start` for one cycle, raises `tx_active` and sets bit 2. `tx_eol_done` clears bit 2 and `tx_active` one cycle later.
- R6: Any single bit of `tx_abort` while running clears bit 2 and `tx_active` one cycle later. The four bits are excessive collisions, excessive deferral, FIFO underrun and byte-count mismatch.
- R7: A set halt bit is looked at only in a cycle where `tx_stat_wb` is high. There it clears bits 2 and 3 and pulses `tx_halted` one cycle later. If an abort or end-of-list arrives in the same cycle, the halt does not count and `tx_halted` stays low.
- R8: Writing 1 to bit 2 while `cam_busy` is high does not start transmission. Instead `cmd_err` pulses for one cycle and `tx_active` stays low.
- R9: A write with bits 0 and 1 both at 1 while disabled leaves the receiver disabled, because disable takes priority.
- R10: A read returns `rd_valid` high one cycle after `rd_en`. The returned `rd_data` holds the command bits as they stood at the `rd_en` edge, including the state where both receive bits are set.
- R11: The halt bit written while idle reads as 1 for one cycle and then clears without effect.
- R12: Hardware reset and `soft_rst` both leave the register reading 0x02, with the receiver disabled and the transmitter idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset of all command bits |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DATA_W | Host write data (command word) |
| rd_en | input | 1 | Host read strobe |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | DATA_W | Read data, live command bits |
| rx_busy | input | 1 | MAC is receiving a packet |
| net_active | input | 1 | Network carrier or activity present |
| tx_eol_done | input | 1 | End-of-list reached and last transmission complete |
| tx_abort | input | N_ABORT | Transmit abort flags |
| tx_stat_wb | input | 1 | Transmit status field written back |
| cam_busy | input | 1 | Address-table load command active |
| rx_buf_en | output | 1 | Enable to the receive buffer engine |
| tx_active | output | 1 | Transmit sequencer run level |
| tx_start | output | 1 | One-cycle start strobe to the transmit sequencer |
| tx_halted | output | 1 | One-cycle pulse when a halt takes effect |
| cmd_err | output | 1 | One-cycle pulse on an illegal start during an address-table load |

## Verification
A halt that is taking effect can meet a transmit abort or an end-of-list in the same cycle. The bench provokes this on purpose: it sets the halt bit during a run, then raises `tx_stat_wb` in the same cycle as one abort flag. It then requires that transmission stops with no `tx_halted` pulse. A host write can also land in the same cycle as the end of a deferred receive change. The random phase produces writes during both wait states as `rx_busy` and `net_active` fall, and a behavioural model judges every cycle, with the write taking precedence.

// File: rtl/ncr_pkg.sv
package ncr_pkg;

    localparam int BIT_RX_EN   = 0;
    localparam int BIT_RX_DIS  = 1;
    localparam int BIT_TX_GO   = 2;
    localparam int BIT_TX_HALT = 3;
    localparam int CMD_BITS    = 4;

    typedef enum logic [1:0] {
        RX_OFF      = 2'd0,
        RX_ON       = 2'd1,
        RX_EN_WAIT  = 2'd2,
        RX_DIS_WAIT = 2'd3
    } rx_state_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_RUN  = 1'b1
    } tx_state_e;

endpackage

// File: rtl/ncr_rx_ctl.sv
module ncr_rx_ctl
    import ncr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic wr_en,
    input  logic wr_rx_en,
    input  logic wr_rx_dis,
    input  logic rx_busy,
    input  logic net_active,
    output logic en_bit,
    output logic dis_bit,
    output logic buf_en
);

    rx_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d = RX_OFF;
        end else begin
            unique case (st_q)
                RX_OFF: begin
                    // disable wins when both are written together
                    if (wr_en && wr_rx_en && !wr_rx_dis)
                        st_d = rx_busy ? RX_EN_WAIT : RX_ON;
                end
                RX_ON: begin
                    if (wr_en && wr_rx_dis)
                        st_d = rx_busy ? RX_DIS_WAIT : RX_OFF;
                end
                RX_EN_WAIT: begin
                    if (wr_en && !wr_rx_en)  st_d = RX_OFF;
                    else if (!net_active)    st_d = RX_ON;
                end
                RX_DIS_WAIT: begin
                    if (wr_en && !wr_rx_dis) st_d = RX_ON;
                    else if (!rx_busy)       st_d = RX_OFF;
                end
                default: st_d = RX_OFF;
            endcase
        end
    end

    always_comb begin
        en_bit  = (st_q != RX_OFF);
        dis_bit = (st_q != RX_ON);
        buf_en  = (st_q == RX_ON) || (st_q == RX_DIS_WAIT);
    end

endmodule

// File: rtl/ncr_tx_ctl.sv
module ncr_tx_ctl
    import ncr_pkg::*;
#(
    parameter int N_ABORT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               wr_en,
    input  logic               wr_go,
    input  logic               wr_halt,
    input  logic               cam_busy,
    input  logic               eol_done,
    input  logic [N_ABORT-1:0] abort,
    input  logic               stat_wb,
    output logic               go_bit,
    output logic               halt_bit,
    output logic               start_pls,
    output logic               halted_pls,
    output logic               err_pls
);

    tx_state_e st_q, st_d;
    logic      halt_q, halt_d;
    logic      start_d, halted_d, err_d;
    logic      finish, halt_hit;

    assign finish   = (|abort) || eol_done;
    assign halt_hit = stat_wb && halt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= TX_IDLE;
            halt_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            halt_q <= halt_d;
        end
    end

    always_comb begin
        st_d     = st_q;
        halt_d   = halt_q;
        start_d  = 1'b0;
        halted_d = 1'b0;
        err_d    = 1'b0;
        if (soft_rst) begin
            st_d   = TX_IDLE;
            halt_d = 1'b0;
        end else begin
            unique case (st_q)
                TX_IDLE: begin
                    halt_d = wr_en && wr_halt;
                    if (wr_en && wr_go) begin
                        if (cam_busy) begin
                            err_d = 1'b1;
                        end else begin
                            st_d    = TX_RUN;
                            start_d = 1'b1;
                        end
                    end
                end
                TX_RUN: begin
                    if (finish || halt_hit) begin
                        st_d     = TX_IDLE;
                        halt_d   = 1'b0;
                        halted_d = !finish;
                    end else if (wr_en && wr_halt) begin
                        halt_d = 1'b1;
                    end
                end
                default: st_d = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pls  <= 1'b0;
            halted_pls <= 1'b0;
            err_pls    <= 1'b0;
        end else begin
            start_pls  <= start_d;
            halted_pls <= halted_d;
            err_pls    <= err_d;
        end
    end

    assign go_bit   = (st_q == TX_RUN);
    assign halt_bit = halt_q;

endmodule

// File: rtl/ncr_rd_port.sv
module ncr_rd_port
    import ncr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [CMD_BITS-1:0] bits,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int PAD_W = DATA_W - CMD_BITS;

    logic [DATA_W-1:0] word;

    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {{PAD_W{1'b0}}, bits};
        end else begin : g_nopad
            assign word = bits[DATA_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? word : '0;
        end
    end

endmodule

// File: rtl/netctl_cmd_reg.sv
module netctl_cmd_reg
    import ncr_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int N_ABORT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               rx_busy,
    input  logic               net_active,
    input  logic               tx_eol_done,
    input  logic [N_ABORT-1:0] tx_abort,
    input  logic               tx_stat_wb,
    input  logic               cam_busy,
    output logic               rx_buf_en,
    output logic               tx_active,
    output logic               tx_start,
    output logic               tx_halted,
    output logic               cmd_err
);

    logic rx_en_bit, rx_dis_bit, tx_go_bit, tx_halt_bit;
    logic [CMD_BITS-1:0] cmd_bits;

    ncr_rx_ctl u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .wr_en      (wr_en),
        .wr_rx_en   (wr_data[BIT_RX_EN]),
        .wr_rx_dis  (wr_data[BIT_RX_DIS]),
        .rx_busy    (rx_busy),
        .net_active (net_active),
        .en_bit     (rx_en_bit),
        .dis_bit    (rx_dis_bit),
        .buf_en     (rx_buf_en)
    );

    ncr_tx_ctl #(.N_ABORT(N_ABORT)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .wr_en      (wr_en),
        .wr_go      (wr_data[BIT_TX_GO]),
        .wr_halt    (wr_data[BIT_TX_HALT]),
        .cam_busy   (cam_busy),
        .eol_done   (tx_eol_done),
        .abort      (tx_abort),
        .stat_wb    (tx_stat_wb),
        .go_bit     (tx_go_bit),
        .halt_bit   (tx_halt_bit),
        .start_pls  (tx_start),
        .halted_pls (tx_halted),
        .err_pls    (cmd_err)
    );

    always_comb begin
        cmd_bits              = '0;
        cmd_bits[BIT_RX_EN]   = rx_en_bit;
        cmd_bits[BIT_RX_DIS]  = rx_dis_bit;
        cmd_bits[BIT_TX_GO]   = tx_go_bit;
        cmd_bits[BIT_TX_HALT] = tx_halt_bit;
    end

    ncr_rd_port #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .bits     (cmd_bits),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign tx_active = tx_go_bit;

endmodule

// File: rtl/ncr_chk.sv
module ncr_chk
    import ncr_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int N_ABORT = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               soft_rst,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wr_data,
    input logic               rd_en,
    input logic               rd_valid,
    input logic               rx_busy,
    input logic               net_active,
    input logic [N_ABORT-1:0] tx_abort,
    input logic               cam_busy,
    input logic               rx_buf_en,
    input logic               tx_start,
    input logic               tx_halted,
    input logic               cmd_err,
    input logic               rx_en_bit,
    input logic               rx_dis_bit,
    input logic               tx_go_bit,
    input logic               tx_halt_bit
);

    a_r12_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> rx_dis_bit && !rx_en_bit && !tx_go_bit && !tx_halt_bit);

    a_r9_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst && wr_en && wr_data[BIT_RX_EN] && wr_data[BIT_RX_DIS] && !rx_en_bit
        |=> !rx_en_bit);

    a_r2_enable_waits: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en_bit && rx_dis_bit && !rx_buf_en && net_active && !soft_rst && !wr_en
        |=> rx_en_bit && rx_dis_bit && !rx_buf_en);

    a_r3_disable_waits: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en_bit && rx_dis_bit && rx_buf_en && rx_busy && !soft_rst && !wr_en
        |=> rx_buf_en && rx_dis_bit);

    a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go_bit && (|tx_abort) |=> !tx_go_bit);

    a_r8_load_conflict: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst && !tx_go_bit && wr_en && wr_data[BIT_TX_GO] && cam_busy
        |=> cmd_err && !tx_start && !tx_go_bit);

    a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r11_idle_halt_drops: assert property (@(posedge clk) disable iff (!rst_n)
        tx_halt_bit && !tx_go_bit && !(wr_en && wr_data[BIT_TX_HALT])
        |=> !tx_halt_bit);

    a_r5_start_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_go_bit) |-> tx_start);

    a_r7_halted_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_halted |-> !tx_go_bit && !tx_halt_bit);

endmodule

bind netctl_cmd_reg ncr_chk #(.DATA_W(DATA_W), .N_ABORT(N_ABORT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_valid    (rd_valid),
    .rx_busy     (rx_busy),
    .net_active  (net_active),
    .tx_abort    (tx_abort),
    .cam_busy    (cam_busy),
    .rx_buf_en   (rx_buf_en),
    .tx_start    (tx_start),
    .tx_halted   (tx_halted),
    .cmd_err     (cmd_err),
    .rx_en_bit   (rx_en_bit),
    .rx_dis_bit  (rx_dis_bit),
    .tx_go_bit   (tx_go_bit),
    .tx_halt_bit (tx_halt_bit)
);

// File: tb/netctl_cmd_reg_tb.sv
module netctl_cmd_reg_tb;

    localparam int DW = 8;
    localparam int NA = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          rx_busy = 1'b0;
    logic          net_active = 1'b0;
    logic          tx_eol_done = 1'b0;
    logic [NA-1:0] tx_abort = '0;
    logic          tx_stat_wb = 1'b0;
    logic          cam_busy = 1'b0;
    logic          rx_buf_en, tx_active, tx_start, tx_halted, cmd_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    netctl_cmd_reg #(.DATA_W(DW), .N_ABORT(NA)) u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .rx_busy(rx_busy), .net_active(net_active),
        .tx_eol_done(tx_eol_done), .tx_abort(tx_abort),
        .tx_stat_wb(tx_stat_wb), .cam_busy(cam_busy),
        .rx_buf_en(rx_buf_en), .tx_active(tx_active),
        .tx_start(tx_start), .tx_halted(tx_halted), .cmd_err(cmd_err)
    );

    // behavioural reference model
    bit m_en, m_dis, m_tx, m_halt, m_pend_en;
    bit m_start, m_halted, m_err, m_rdv;
    logic [DW-1:0] m_rdd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = 0; m_dis = 1; m_tx = 0; m_halt = 0; m_pend_en = 0;
            m_start = 0; m_halted = 0; m_err = 0; m_rdv = 0; m_rdd = '0;
        end else begin
            bit o_tx, o_halt, ending;
            o_tx = m_tx; o_halt = m_halt;
            m_rdv = rd_en;
            m_rdd = rd_en ? DW'({m_halt, m_tx, m_dis, m_en}) : '0;
            m_start = 0; m_halted = 0; m_err = 0;
            if (soft_rst) begin
                m_en = 0; m_dis = 1; m_tx = 0; m_halt = 0; m_pend_en = 0;
            end else begin
                if (!m_en && m_dis) begin
                    if (wr_en && wr_data[0] && !wr_data[1]) begin
                        m_en = 1;
                        if (rx_busy) m_pend_en = 1; else m_dis = 0;
                    end
                end else if (m_en && !m_dis) begin
                    if (wr_en && wr_data[1]) begin
                        m_dis = 1;
                        if (rx_busy) m_pend_en = 0; else m_en = 0;
                    end
                end else if (m_pend_en) begin
                    if (wr_en && !wr_data[0]) m_en = 0;
                    else if (!net_active) m_dis = 0;
                end else begin
                    if (wr_en && !wr_data[1]) m_dis = 0;
                    else if (!rx_busy) m_en = 0;
                end
                if (!o_tx) begin
                    m_halt = wr_en && wr_data[3];
                    if (wr_en && wr_data[2]) begin
                        if (cam_busy) m_err = 1;
                        else begin m_tx = 1; m_start = 1; end
                    end
                end else begin
                    ending = (tx_abort != 0) || tx_eol_done;
                    if (ending) begin
                        m_tx = 0; m_halt = 0;
                    end else if (tx_stat_wb && o_halt) begin
                        m_tx = 0; m_halt = 0; m_halted = 1;
                    end else if (wr_en && wr_data[3]) begin
                        m_halt = 1;
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R10 model rd_valid", 32'(rd_valid), 32'(m_rdv));
            chk("R10 model rd_data", 32'(rd_data), 32'(m_rdd));
            chk("R2 model rx_buf_en", 32'(rx_buf_en),
                32'((m_en && !m_dis) || (m_en && m_dis && !m_pend_en)));
            chk("R5 model tx_active", 32'(tx_active), 32'(m_tx));
            chk("R5 model tx_start", 32'(tx_start), 32'(m_start));
            chk("R7 model tx_halted", 32'(tx_halted), 32'(m_halted));
            chk("R8 model cmd_err", 32'(cmd_err), 32'(m_err));
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input string tag, input logic [DW-1:0] exp);
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
        chk({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic summary();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        rd("R12 reset state", 8'h02);
        chk("R12 reset rx_buf_en", 32'(rx_buf_en), 32'd0);

        wr(8'h01);
        chk("R1 immediate enable buf", 32'(rx_buf_en), 32'd1);
        rd("R1 immediate enable bits", 8'h01);

        rx_busy = 1; net_active = 1;
        wr(8'h02);
        rd("R3 deferred disable both set", 8'h03);
        chk("R3 still buffering", 32'(rx_buf_en), 32'd1);
        rx_busy = 0;
        tick();
        rd("R3 disable took effect", 8'h02);
        chk("R3 buffering stopped", 32'(rx_buf_en), 32'd0);

        rx_busy = 1;
        wr(8'h01);
        rd("R2 deferred enable both set", 8'h03);
        chk("R2 not buffering mid packet", 32'(rx_buf_en), 32'd0);
        wr(8'h00);
        rd("R4 pending enable cancelled", 8'h02);
        wr(8'h01);
        rx_busy = 0;
        tick();
        rd("R2 waits for idle network", 8'h03);
        net_active = 0;
        tick();
        chk("R2 enable took effect", 32'(rx_buf_en), 32'd1);
        rd("R2 enabled bits", 8'h01);

        rx_busy = 1; net_active = 1;
        wr(8'h02);
        wr(8'h01);
        rd("R4 pending disable cancelled", 8'h01);
        chk("R4 buffering kept", 32'(rx_buf_en), 32'd1);
        rx_busy = 0; net_active = 0;

        wr(8'h03);
        wr(8'h03);
        rd("R9 disable wins", 8'h02);
        chk("R9 buffering off", 32'(rx_buf_en), 32'd0);

        wr(8'h04);
        chk("R5 start strobe", 32'(tx_start), 32'd1);
        chk("R5 running", 32'(tx_active), 32'd1);
        rd("R5 go bit set", 8'h06);
        tx_eol_done = 1; tick(); tx_eol_done = 0;
        chk("R5 eol clears", 32'(tx_active), 32'd0);

        for (int i = 0; i < NA; i++) begin
            wr(8'h04);
            tx_abort = NA'(1) << i;
            tick();
            tx_abort = '0;
            chk($sformatf("R6 abort flag %0d clears", i), 32'(tx_active), 32'd0);
        end

        wr(8'h04);
        wr(8'h08);
        rd("R7 halt pending", 8'h0E);
        tick();
        chk("R7 halt waits for writeback", 32'(tx_active), 32'd1);
        tx_stat_wb = 1; tick(); tx_stat_wb = 0;
        chk("R7 halted pulse", 32'(tx_halted), 32'd1);
        chk("R7 stopped", 32'(tx_active), 32'd0);
        rd("R7 bits cleared", 8'h02);

        wr(8'h08);
        rd("R11 idle halt visible", 8'h0A);
        rd("R11 idle halt dropped", 8'h02);

        cam_busy = 1;
        wr(8'h04);
        chk("R8 error pulse", 32'(cmd_err), 32'd1);
        chk("R8 not started", 32'(tx_active), 32'd0);
        cam_busy = 0;

        wr(8'h04);
        wr(8'h08);
        tx_stat_wb = 1; tx_abort = 4'b0010;
        tick();
        tx_stat_wb = 0; tx_abort = '0;
        chk("R7 abort beats halt no pulse", 32'(tx_halted), 32'd0);
        chk("R6 abort with halt stops", 32'(tx_active), 32'd0);

        wr(8'h01);
        wr(8'h04);
        soft_rst = 1; tick(); soft_rst = 0;
        chk("R12 soft reset tx idle", 32'(tx_active), 32'd0);
        chk("R12 soft reset rx off", 32'(rx_buf_en), 32'd0);
        rd("R12 soft reset bits", 8'h02);

        for (int n = 0; n < 4000; n++) begin
            wr_en       = ($urandom_range(0, 3) == 0);
            wr_data     = DW'($urandom_range(0, 15));
            rd_en       = $urandom_range(0, 1);
            if ($urandom_range(0, 7) == 0) rx_busy = ~rx_busy;
            net_active  = rx_busy | ($urandom_range(0, 3) == 0);
            tx_eol_done = ($urandom_range(0, 15) == 0);
            tx_abort    = ($urandom_range(0, 15) == 0) ? NA'(1) << $urandom_range(0, NA-1) : '0;
            tx_stat_wb  = ($urandom_range(0, 5) == 0);
            cam_busy    = ($urandom_range(0, 3) == 0);
            soft_rst    = ($urandom_range(0, 99) == 0);
            tick();
        end
        wr_en = 0; rd_en = 0; soft_rst = 0; tx_abort = '0;
        tx_eol_done = 0; tx_stat_wb = 0;
        tick();
        summary();
    end

endmodule